// File: doc/BRIEF.md
# Drift-Trimmed Fractional Time Counter

This block keeps a precision time value made of a seconds count and a binary sub-second count. It runs from a reference clock that is faster than the wanted update rate. On every reference clock cycle a 32-bit phase accumulator adds a programmable step value, called the addend. The time value advances only when that addition overflows, so the average update rate is the reference frequency multiplied by addend / 2^32.

For a 50 MHz update rate the addend is 2^32 divided by the ratio of the reference clock to 50 MHz. A 66 MHz reference therefore uses 0xC1F07C1F. Each update adds a programmable sub-second increment, by default 43. When the sub-second count passes 2^31 it wraps, keeps the remainder, and the seconds count rises by one.

Software measures drift against a remote master and corrects it by rewriting the addend. For example, a reference that has slowed to 65 MHz needs 0xC4EC4EC4, and one that has risen to 67 MHz needs 0xBF0B7672. A load strobe sets the time directly.

Top module: `ptp_fine_clock`

## Requirements
- R1: While reset is asserted and right after it is released, `sec_o` and `subsec_o` read 0, the accumulator is 0, the addend is `DEF_ADDEND` (0xC1F07C1F) and the increment is `DEF_INC` (43).
- R2: On every clock without a load, the addend is added to the 32-bit accumulator modulo 2^32. The time advances in that cycle only if the addition carries out of bit 31. From an accumulator of 0 with a constant addend A, after N cycles exactly floor(N·A/2^32) updates have happened.
- R3: Each update adds the current increment to `subsec_o`.
- R4: `subsec_o` is 31 bits wide. When an update takes it to 2^31 or beyond, it keeps the sum minus 2^31 and `sec_o` increments, wrapping modulo 2^32.
- R5: A cycle with `load_en` high sets `sec_o` and `subsec_o` to `load_sec` and `load_subsec` on the next edge and clears the accumulator. No update happens in that cycle.
- R6: A write with `addend_we` replaces the addend at the clock edge. The addition in the write cycle still uses the old addend, and the accumulator is not cleared.
- R7: A write with `inc_we` replaces the increment at the clock edge. An update in the write cycle still adds the old increment.
- R8: With an addend of 0 and no load, the time holds its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addend_we | input | 1 | Write strobe for the addend |
| addend_wdata | input | 32 | New addend value |
| inc_we | input | 1 | Write strobe for the sub-second increment |
| inc_wdata | input | 8 | New increment value |
| load_en | input | 1 | Time load strobe |
| load_sec | input | 32 | Seconds value to load |
| load_subsec | input | 31 | Sub-second value to load |
| sec_o | output | 32 | Current seconds |
| subsec_o | output | 31 | Current sub-seconds |

## Verification
Every result is registered, so any input pattern is visible on `sec_o` and `subsec_o` exactly one rising edge after the cycle that presents it. An addend or increment write therefore first shows up in the outputs two edges after the write: one edge to store the new value and one edge to use it. The bench drives inputs on the falling edge. It updates its own model of the counter on the rising edge from the same inputs, and compares outputs on the following falling edge, so every comparison falls in the first cycle where the result is due. Directed sequences check the expected counts after a known number of cycles, the wrap edges and the write-cycle timing. A seeded random phase mixes writes, loads and near-wrap values.

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock #(
  parameter int ACC_W = 32,
  parameter int SUB_W = 31,
  parameter int SEC_W = 32,
  parameter int INC_W = 8,
  parameter logic [ACC_W-1:0] DEF_ADDEND = 32'hC1F07C1F,
  parameter logic [INC_W-1:0] DEF_INC = 8'd43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  input  logic             inc_we,
  input  logic [INC_W-1:0] inc_wdata,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [SUB_W-1:0] load_subsec,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] subsec_o
);

  localparam int PAD_W = SUB_W + 1 - INC_W;

  logic [ACC_W-1:0] acc, addend;
  logic [INC_W-1:0] inc;
  logic [ACC_W:0]   acc_sum;
  logic [SUB_W:0]   sub_sum;
  logic             tick;

  assign acc_sum = {1'b0, acc} + {1'b0, addend};
  assign tick    = acc_sum[ACC_W] & ~load_en;
  assign sub_sum = {1'b0, subsec_o} + {{PAD_W{1'b0}}, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend <= DEF_ADDEND;
      inc    <= DEF_INC;
    end else begin
      if (addend_we) addend <= addend_wdata;
      if (inc_we)    inc    <= inc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      sec_o    <= '0;
      subsec_o <= '0;
    end else if (load_en) begin
      acc      <= '0;
      sec_o    <= load_sec;
      subsec_o <= load_subsec;
    end else begin
      acc <= acc_sum[ACC_W-1:0];
      if (tick) begin
        subsec_o <= sub_sum[SUB_W-1:0];
        if (sub_sum[SUB_W]) sec_o <= sec_o + 1'b1;
      end
    end
  end

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_en) |-> (sec_o == $past(load_sec) && subsec_o == $past(load_subsec) && acc == '0));

  p_acc_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addend_we) && !$past(load_en)) |-> acc == ACC_W'($past(acc) + $past(addend)));

  p_addend_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addend_we) |-> addend == $past(addend_wdata));

  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_en) |-> (sec_o == $past(sec_o) || sec_o == SEC_W'($past(sec_o) + 1'b1)));

  p_hold_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && ({1'b0, $past(acc)} + {1'b0, $past(addend)}) < (ACC_W+1)'(1) << ACC_W)
      |-> ($stable(sec_o) && $stable(subsec_o)));

  p_zero_addend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && $past(addend) == '0) |-> $stable(subsec_o));

endmodule

// File: tb/test_ptp_fine_clock.sv
module test_ptp_fine_clock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addend_we = 1'b0;
  logic [31:0] addend_wdata = '0;
  logic        inc_we = 1'b0;
  logic [7:0]  inc_wdata = '0;
  logic        load_en = 1'b0;
  logic [31:0] load_sec = '0;
  logic [30:0] load_subsec = '0;
  logic [31:0] sec_o;
  logic [30:0] subsec_o;

  int checks = 0;
  int errors = 0;

  longint unsigned m_acc, m_add, m_inc, m_sec, m_sub;

  always #4 clk = ~clk;

  ptp_fine_clock i_ptp_fine_clock (
    .clk(clk), .rst_n(rst_n),
    .addend_we(addend_we), .addend_wdata(addend_wdata),
    .inc_we(inc_we), .inc_wdata(inc_wdata),
    .load_en(load_en), .load_sec(load_sec), .load_subsec(load_subsec),
    .sec_o(sec_o), .subsec_o(subsec_o)
  );

  task automatic check(input string tag, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic longint unsigned updates_after(input longint unsigned n, input longint unsigned a);
    return (n * a) >> 32;
  endfunction

  task automatic model_step();
    longint unsigned s, t;
    if (load_en) begin
      m_acc = 0; m_sec = load_sec; m_sub = load_subsec;
    end else begin
      s = m_acc + m_add;
      m_acc = s & 64'hFFFF_FFFF;
      if (s >= 64'h1_0000_0000) begin
        t = m_sub + m_inc;
        if (t >= 64'h8000_0000) begin
          t -= 64'h8000_0000;
          m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
        end
        m_sub = t;
      end
    end
    if (addend_we) m_add = addend_wdata;
    if (inc_we) m_inc = inc_wdata;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " sec"}, sec_o, m_sec);
    check({tag, " subsec"}, subsec_o, m_sub);
    addend_we = 1'b0; inc_we = 1'b0; load_en = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] s, input logic [30:0] ss, input string tag);
    load_sec = s; load_subsec = ss; load_en = 1'b1;
    cyc(tag);
  endtask

  task automatic set_addend(input logic [31:0] a, input string tag);
    addend_wdata = a; addend_we = 1'b1;
    cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 sec in reset", sec_o, 0);
    check("R1 subsec in reset", subsec_o, 0);
    rst_n = 1'b1;
    m_acc = 0; m_add = 32'hC1F07C1F; m_inc = 43; m_sec = 0; m_sub = 0;
    check("R1 sec after release", sec_o, 0);
    check("R1 subsec after release", subsec_o, 0);

    // R2 R3 R1: default addend and increment from reset
    for (int i = 0; i < 100; i++) cyc("R2");
    check("R2 updates in 100 cycles", subsec_o, updates_after(100, 32'hC1F07C1F) * 43);

    // R8: zero addend freezes time
    set_addend(32'h0, "R8");
    cyc("R8");
    begin
      logic [30:0] held;
      held = subsec_o;
      for (int i = 0; i < 50; i++) cyc("R8");
      check("R8 frozen subsec", subsec_o, held);
    end

    // R4: wrap into seconds with remainder
    set_addend(32'hFFFF_FFFF, "R4");
    do_load(32'h0000_0010, 31'h7FFF_FFF6, "R5");
    check("R5 loaded subsec", subsec_o, 31'h7FFF_FFF6);
    cyc("R4");
    cyc("R4");
    check("R4 sec carried", sec_o, 32'h11);
    check("R4 subsec remainder", subsec_o, 33);
    do_load(32'hFFFF_FFFF, 31'h7FFF_FFFF, "R5");
    cyc("R4"); cyc("R4");
    check("R4 sec wraps", sec_o, 0);
    check("R4 sec wrap remainder", subsec_o, 42);

    // R5: load overrides a carry in the same cycle
    cyc("R5");
    load_sec = 32'hABCD; load_subsec = 31'd5; load_en = 1'b1;
    cyc("R5");
    check("R5 load wins over carry", subsec_o, 5);

    // R6: addend change keeps accumulator, old addend used in write cycle
    set_addend(32'h8000_0000, "R6");
    do_load(32'd0, 31'd0, "R6");
    cyc("R6");
    addend_wdata = 32'h4000_0000; addend_we = 1'b1;
    cyc("R6");
    check("R6 old addend carried in write cycle", subsec_o, 43);
    for (int i = 0; i < 3; i++) cyc("R6");
    check("R6 no carry yet", subsec_o, 43);
    cyc("R6");
    check("R6 fourth new step carries", subsec_o, 86);

    // R7: increment write takes effect after the edge
    set_addend(32'hFFFF_FFFF, "R7");
    do_load(32'd0, 31'd0, "R7");
    cyc("R7");
    inc_wdata = 8'd100; inc_we = 1'b1;
    cyc("R7");
    check("R7 old increment in write cycle", subsec_o, 43);
    cyc("R7");
    check("R7 new increment used", subsec_o, 143);

    // Drift values
    set_addend(32'hC4EC4EC4, "R2");
    for (int i = 0; i < 40; i++) cyc("R2");
    set_addend(32'hBF0B7672, "R2");
    for (int i = 0; i < 40; i++) cyc("R2");

    // Random mix, R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) begin
        load_sec = $urandom;
        load_subsec = (($urandom % 2) != 0) ? 31'(31'h7FFF_FFFF - ($urandom % 300)) : 31'($urandom);
        load_en = 1'b1;
      end
      if (r >= 10 && r < 16) begin
        addend_wdata = (r == 10) ? 32'h0 : (r == 11 ? 32'hFFFF_FFFF : 32'($urandom));
        addend_we = 1'b1;
      end
      if (r >= 20 && r < 23) begin
        inc_wdata = 8'($urandom);
        inc_we = 1'b1;
      end
      cyc("R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule